// File: doc/BRIEF.md
# I2C Target with General-Call Address Programming

This block is the target side of a two-wire serial bus. It watches the clock and data lines through synchronizers running on the system clock, finds START and STOP conditions, collects the 7-bit address and direction bit, and acknowledges either its own address or the broadcast address 0x00. After a write address it takes data bytes into a single holding register. After a read address it fetches bytes from a transmit port and shifts them out. Both lines are open-drain: the block drives only output enables that pull a line low.

The upper address bits are fixed by a parameter. The lower configurable bits come either from input pins or from a soft register. A broadcast write that carries a set-address command code, followed by one value byte, loads that soft register. When the holding register is still full, or no transmit byte is ready, the block holds the clock line low until the local side catches up. A parameter selects this clock stretching. Any START or STOP ends whatever transfer is in progress.

Top module: `i2c_target`

## Requirements
- R1: After reset both line enables are released, `rx_valid` is 0 and `tx_req` is 0. An address byte whose upper seven bits equal the own address, with bit 0 = 0 (write), is acknowledged by pulling SDA low during the ninth clock. Bytes travel MSB first.
- R2: An address byte that matches neither the own address nor the broadcast address gets no acknowledge. Data bytes that follow it up to the next START get no acknowledge and never reach `rx_data`.
- R3: The broadcast address byte 0x00 (address 0, write) is acknowledged. The byte 0x01 (address 0, read) is not acknowledged.
- R4: After a broadcast address, the command byte equal to `GC_SET_CMD` (default 0x04) is acknowledged. The next byte is acknowledged, and its low `CFG_W` bits become the soft configurable bits. While `cfg_soft` = 1 the own address is {fixed bits, soft bits}. Broadcast bytes never reach `rx_data`.
- R5: After a broadcast address, any other command byte is not acknowledged and has no effect: the soft bits are unchanged and `rx_valid` stays 0.
- R6: While `cfg_soft` = 0 the low `CFG_W` address bits are taken from `cfg_pins`. The fixed upper bits default to 0b1010.
- R7: A data byte written to a matched address while the holding register is empty is acknowledged and appears on `rx_data`. `rx_valid` goes to 1 and stays there until a `rx_take` pulse clears it.
- R8: With stretching enabled, a data byte that arrives while the holding register is full is not dropped. SCL is held low after the eighth bit until `rx_take` empties the register. The byte is then loaded and acknowledged.
- R9: After a read address is acknowledged, `tx_req` rises. The byte accepted on the cycle `tx_req` and `tx_valid` are both 1 is driven MSB first, and SDA changes only while SCL is low.
- R10: When the master acknowledges a read byte, the next byte is requested. When the master does not acknowledge, SDA is released and no further byte is requested.
- R11: With stretching enabled, if `tx_valid` is 0 when a read byte is needed, SCL is held low until `tx_valid` is 1.
- R12: A START in the middle of a byte discards the partial byte and restarts address reception. A STOP in the middle of a byte discards it and sends the block idle, so later bytes without a START are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_pins | input | CFG_W | Configurable address bits from pins |
| cfg_soft | input | 1 | 1 selects the command-written address bits |
| rx_data | output | 8 | Holding register contents |
| rx_valid | output | 1 | Holding register full |
| rx_take | input | 1 | Pulse to empty the holding register |
| tx_data | input | 8 | Next byte to transmit |
| tx_valid | input | 1 | `tx_data` is ready |
| tx_req | output | 1 | A transmit byte is needed now |

## Verification
The hardest case to reach from the ports is a byte that arrives while the holding register is still occupied. The bench sets this up by writing two bytes back to back without draining the first. A parallel process waits for the clock enable to rise, confirms that SCL stays low although the master has released it, and only then pulses `rx_take`. The read-side stretch is set up in the same way by withholding `tx_valid`. The abort cases are produced by a master model that can issue a repeated START or a STOP after a chosen number of data bits.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RXWT,
    ST_RACK,
    ST_TXLD,
    ST_TX,
    ST_TACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    GC_OFF,
    GC_CMD,
    GC_VAL,
    GC_END
  } gc_phase_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw;
  logic [N_LINES-1:0] synced;
  logic [N_LINES-1:0] prev_q;
  logic               scl_p;
  logic               sda_p;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] ff_q;
    logic [SYNC_STAGES-1:0] ff_d;
    assign ff_d = {ff_q[SYNC_STAGES-2:0], raw[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= '1;
      else        ff_q <= ff_d;
    end
    assign synced[g] = ff_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= synced;
  end

  assign scl_s = synced[1];
  assign sda_s = synced[0];
  assign scl_p = prev_q[1];
  assign sda_p = prev_q[0];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_tgt_addr.sv
module i2c_tgt_addr
  import i2c_tgt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ADDR_FIXED = 7'h50,
  parameter int                CFG_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_pins,
  input  logic              cfg_soft,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_val,
  output logic [ADDR_W-1:0] own_addr
);
  localparam int FIX_W = ADDR_W - CFG_W;

  logic [CFG_W-1:0] soft_q;
  logic [CFG_W-1:0] soft_d;
  logic [CFG_W-1:0] low_bits;

  always_comb begin
    soft_d = soft_q;
    if (cfg_wr) soft_d = cfg_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_q <= '0;
    else        soft_q <= soft_d;
  end

  assign low_bits = cfg_soft ? soft_q : cfg_pins;
  assign own_addr = {ADDR_FIXED[ADDR_W-1 -: FIX_W], low_bits};

  // R5: the soft bits move only on a command write
  a_r5_soft_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(soft_q));
endmodule

// File: rtl/i2c_tgt_rxhold.sv
module i2c_tgt_rxhold
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  input  logic              take,
  output logic              valid,
  output logic [BYTE_W-1:0] dout
);
  logic              valid_q, valid_d;
  logic [BYTE_W-1:0] data_q;

  always_comb begin
    valid_d = valid_q;
    if (take) valid_d = 1'b0;
    if (load) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= din;
  end

  assign valid = valid_q;
  assign dout  = data_q;

  // R7: a held byte is never overwritten
  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid_q);
endmodule

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core
  import i2c_tgt_pkg::*;
#(
  parameter int                CFG_W      = 3,
  parameter logic [BYTE_W-1:0] GC_SET_CMD = 8'h04,
  parameter bit                STRETCH_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              rx_full,
  output logic              rx_load,
  output logic [BYTE_W-1:0] rx_byte,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_req,
  output logic              cfg_wr,
  output logic [CFG_W-1:0]  cfg_val,
  output logic              sda_oe,
  output logic              scl_oe
);
  localparam logic [3:0] CNT_FULL = 4'd8;
  localparam logic [3:0] CNT_LAST = 4'd7;

  tgt_state_e        state_q, state_d;
  gc_phase_e         gc_q, gc_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d;
  logic              sda_oe_q, sda_oe_d;
  logic              scl_oe_q, scl_oe_d;
  logic              own_hit, gc_hit;

  assign own_hit = (sh_q[BYTE_W-1:1] == own_addr);
  assign gc_hit  = (sh_q == '0);

  always_comb begin
    state_d  = state_q;
    gc_d     = gc_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    rw_d     = rw_q;
    sda_oe_d = sda_oe_q;
    scl_oe_d = scl_oe_q;
    rx_load  = 1'b0;
    cfg_wr   = 1'b0;

    case (state_q)
      ST_ADDR: begin
        if (scl_rise) begin
          sh_d  = {sh_q[BYTE_W-2:0], sda_s};
          cnt_d = cnt_q + 4'd1;
        end else if (scl_fall && cnt_q == CNT_FULL) begin
          if (gc_hit) begin
            gc_d     = GC_CMD;
            rw_d     = 1'b0;
            sda_oe_d = 1'b1;
            state_d  = ST_AACK;
          end else if (own_hit) begin
            gc_d     = GC_OFF;
            rw_d     = sh_q[0];
            sda_oe_d = 1'b1;
            state_d  = ST_AACK;
          end else begin
            state_d  = ST_IDLE;
          end
        end
      end
      ST_AACK: begin
        if (scl_fall) begin
          sda_oe_d = 1'b0;
          cnt_d    = '0;
          state_d  = rw_q ? ST_TXLD : ST_RX;
        end
      end
      ST_RX: begin
        if (scl_rise) begin
          sh_d  = {sh_q[BYTE_W-2:0], sda_s};
          cnt_d = cnt_q + 4'd1;
        end else if (scl_fall && cnt_q == CNT_FULL) begin
          case (gc_q)
            GC_CMD: begin
              if (sh_q == GC_SET_CMD) begin
                gc_d     = GC_VAL;
                sda_oe_d = 1'b1;
                state_d  = ST_RACK;
              end else begin
                state_d  = ST_IDLE;
              end
            end
            GC_VAL: begin
              cfg_wr   = 1'b1;
              gc_d     = GC_END;
              sda_oe_d = 1'b1;
              state_d  = ST_RACK;
            end
            GC_END: state_d = ST_IDLE;
            default: begin
              if (!rx_full) begin
                rx_load  = 1'b1;
                sda_oe_d = 1'b1;
                state_d  = ST_RACK;
              end else if (STRETCH_EN) begin
                scl_oe_d = 1'b1;
                state_d  = ST_RXWT;
              end else begin
                state_d  = ST_IDLE;
              end
            end
          endcase
        end
      end
      ST_RXWT: begin
        if (!rx_full) begin
          rx_load  = 1'b1;
          sda_oe_d = 1'b1;
          scl_oe_d = 1'b0;
          state_d  = ST_RACK;
        end
      end
      ST_RACK: begin
        if (scl_fall) begin
          sda_oe_d = 1'b0;
          cnt_d    = '0;
          state_d  = ST_RX;
        end
      end
      ST_TXLD: begin
        if (tx_valid) begin
          sh_d     = tx_data;
          sda_oe_d = ~tx_data[BYTE_W-1];
          scl_oe_d = 1'b0;
          cnt_d    = '0;
          state_d  = ST_TX;
        end else if (STRETCH_EN) begin
          scl_oe_d = 1'b1;
        end else begin
          sh_d     = '1;
          sda_oe_d = 1'b0;
          cnt_d    = '0;
          state_d  = ST_TX;
        end
      end
      ST_TX: begin
        if (scl_fall) begin
          if (cnt_q == CNT_LAST) begin
            sda_oe_d = 1'b0;
            state_d  = ST_TACK;
          end else begin
            sh_d     = {sh_q[BYTE_W-2:0], 1'b1};
            sda_oe_d = ~sh_q[BYTE_W-2];
            cnt_d    = cnt_q + 4'd1;
          end
        end
      end
      ST_TACK: begin
        if (scl_rise && sda_s) state_d = ST_IDLE;
        else if (scl_fall)     state_d = ST_TXLD;
      end
      default: ;
    endcase

    if (stop_det) begin
      state_d  = ST_IDLE;
      gc_d     = GC_OFF;
      sda_oe_d = 1'b0;
      scl_oe_d = 1'b0;
    end else if (start_det) begin
      state_d  = ST_ADDR;
      gc_d     = GC_OFF;
      cnt_d    = '0;
      sda_oe_d = 1'b0;
      scl_oe_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      gc_q     <= GC_OFF;
      cnt_q    <= '0;
      sh_q     <= '0;
      rw_q     <= 1'b0;
      sda_oe_q <= 1'b0;
      scl_oe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      gc_q     <= gc_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      rw_q     <= rw_d;
      sda_oe_q <= sda_oe_d;
      scl_oe_q <= scl_oe_d;
    end
  end

  assign rx_byte = sh_q;
  assign cfg_val = sh_q[CFG_W-1:0];
  assign tx_req  = (state_q == ST_TXLD);
  assign sda_oe  = sda_oe_q;
  assign scl_oe  = scl_oe_q;

  // R9: SDA is only pulled low while SCL is low
  a_r9_sda_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_q) |-> !scl_s);

  // R8: space in the holding register ends the stretch with an ACK
  a_r8_release_on_space: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RXWT && !rx_full && !start_det && !stop_det) |=> (!scl_oe_q && sda_oe_q));

  // R11: an offered transmit byte ends the stretch
  a_r11_tx_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TXLD && tx_valid && !start_det && !stop_det) |=> (!scl_oe_q && !tx_req));

  // R10: a master NACK ends the read
  a_r10_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TACK && scl_rise && sda_s && !start_det && !stop_det) |=> (!tx_req && !sda_oe_q));

  // R12: a START always restarts address reception with the lines released
  a_r12_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_ADDR && cnt_q == '0 && !sda_oe_q && !scl_oe_q));

  // R2: an idle target leaves both lines alone
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!sda_oe_q && !scl_oe_q));
endmodule

// File: rtl/i2c_target.sv
module i2c_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ADDR_FIXED  = 7'h50,
  parameter int                CFG_W       = 3,
  parameter logic [BYTE_W-1:0] GC_SET_CMD  = 8'h04,
  parameter bit                STRETCH_EN  = 1'b1,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [CFG_W-1:0]  cfg_pins,
  input  logic              cfg_soft,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_take,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_req
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] own_addr;
  logic              rx_load;
  logic [BYTE_W-1:0] rx_byte;
  logic              cfg_wr;
  logic [CFG_W-1:0]  cfg_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2c_tgt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_addr #(.ADDR_FIXED(ADDR_FIXED), .CFG_W(CFG_W)) u_addr (
    .clk(clk), .rst_n(rst_int_n), .cfg_pins(cfg_pins), .cfg_soft(cfg_soft),
    .cfg_wr(cfg_wr), .cfg_val(cfg_val), .own_addr(own_addr)
  );

  i2c_tgt_rxhold u_rxhold (
    .clk(clk), .rst_n(rst_int_n), .load(rx_load), .din(rx_byte),
    .take(rx_take), .valid(rx_valid), .dout(rx_data)
  );

  i2c_tgt_core #(.CFG_W(CFG_W), .GC_SET_CMD(GC_SET_CMD), .STRETCH_EN(STRETCH_EN)) u_core (
    .clk(clk), .rst_n(rst_int_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .rx_full(rx_valid), .rx_load(rx_load), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_req(tx_req),
    .cfg_wr(cfg_wr), .cfg_val(cfg_val), .sda_oe(sda_oe), .scl_oe(scl_oe)
  );
endmodule

// File: tb/sim_i2c_target.sv
module sim_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    logic [2:0] pins;
    logic [7:0] addr;
    logic [7:0] data;
    logic       aack;
    logic       dack;
    logic [3:0] req;
  } vec_t;

  // own address = {1010, pins}; 0x00 broadcast; 0x77 is an unknown broadcast command
  localparam vec_t VECS [8] = '{
    '{3'd3, 8'hA6, 8'h5A, 1'b1, 1'b1, 4'd7},  // R7 own write
    '{3'd3, 8'hA8, 8'h11, 1'b0, 1'b0, 4'd2},  // R2 foreign address
    '{3'd6, 8'hAC, 8'hC3, 1'b1, 1'b1, 4'd6},  // R6 pins changed
    '{3'd6, 8'hA6, 8'h22, 1'b0, 1'b0, 4'd6},  // R6 old address dropped
    '{3'd3, 8'h01, 8'h33, 1'b0, 1'b0, 4'd3},  // R3 broadcast read refused
    '{3'd3, 8'h00, 8'h77, 1'b1, 1'b0, 4'd5},  // R5 unknown command
    '{3'd0, 8'hA0, 8'h00, 1'b1, 1'b1, 4'd1},  // R1 all-zero pins
    '{3'd7, 8'hAE, 8'hFF, 1'b1, 1'b1, 4'd1}   // R1 all-one pins
  };

  logic       clk, rst_n;
  logic       scl_m, sda_m;
  logic       scl_line, sda_line;
  logic       scl_oe, sda_oe;
  logic [2:0] cfg_pins;
  logic       cfg_soft;
  logic [7:0] rx_data;
  logic       rx_valid, rx_take;
  logic [7:0] tx_data;
  logic       tx_valid, tx_req;
  int         n_take;
  int         n_chk, n_fail;
  bit         ended;

  function automatic logic [7:0] txpat(input int k);
    logic [7:0] m;
    m = 8'(k * 37);
    return 8'hC5 + m;
  endfunction

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;
  assign tx_data  = txpat(n_take);

  i2c_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_pins(cfg_pins), .cfg_soft(cfg_soft),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_take(rx_take),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_req(tx_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial n_take = 0;
  always @(posedge clk) if (tx_req && tx_valid) n_take <= n_take + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic got);
    sda_m = b;
    wait_q();
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_q();
    got = sda_line;
    wait_q();
    scl_m = 1'b0;
    wait_q();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], g);
    bus_bit(1'b1, g);
    ack = ~g;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, g);
      d[i] = g;
    end
    bus_bit(~mack, g);
  endtask

  task automatic take_pulse();
    rx_take = 1'b1;
    @(negedge clk);
    rx_take = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
    finish_run();
  end

  initial begin
    logic       ack;
    logic       g;
    logic [7:0] d;
    int         base;
    n_chk = 0; n_fail = 0; ended = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1;
    cfg_pins = 3'd3; cfg_soft = 1'b0;
    rx_take = 1'b0; tx_valid = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 reset state
    chk("R1 reset scl_oe", 32'(scl_oe), 0);
    chk("R1 reset sda_oe", 32'(sda_oe), 0);
    chk("R1 reset rx_valid", 32'(rx_valid), 0);
    chk("R1 reset tx_req", 32'(tx_req), 0);

    // table walk
    foreach (VECS[i]) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      cfg_pins = VECS[i].pins;
      bus_start();
      write_byte(VECS[i].addr, ack);
      chk({tag, " addr ack"}, 32'(ack), 32'(VECS[i].aack));
      write_byte(VECS[i].data, ack);
      chk({tag, " data ack"}, 32'(ack), 32'(VECS[i].dack));
      chk({tag, " rx_valid"}, 32'(rx_valid), 32'(VECS[i].dack));
      if (VECS[i].dack) begin
        chk({tag, " rx_data"}, 32'(rx_data), 32'(VECS[i].data));
        take_pulse();
        chk({tag, " rx_take clears"}, 32'(rx_valid), 0);
      end
      bus_stop();
    end
    cfg_pins = 3'd3;

    // R4 set-address broadcast, soft bits = 5 -> address 0x55
    bus_start();
    write_byte(8'h00, ack); chk("R3 broadcast write ack", 32'(ack), 1);
    write_byte(8'h04, ack); chk("R4 set command ack", 32'(ack), 1);
    write_byte(8'h05, ack); chk("R4 value byte ack", 32'(ack), 1);
    chk("R4 broadcast not in rx", 32'(rx_valid), 0);
    bus_stop();
    cfg_soft = 1'b1;
    bus_start();
    write_byte(8'hAA, ack); chk("R4 soft address ack", 32'(ack), 1);
    write_byte(8'h3E, ack); chk("R4 data ack", 32'(ack), 1);
    chk("R4 rx_data", 32'(rx_data), 32'h3E);
    take_pulse();
    bus_stop();
    bus_start();
    write_byte(8'hA6, ack); chk("R4 pin address ignored in soft mode", 32'(ack), 0);
    bus_stop();

    // R5 unknown command leaves soft bits alone
    bus_start();
    write_byte(8'h00, ack);
    write_byte(8'h33, ack); chk("R5 unknown command nack", 32'(ack), 0);
    bus_stop();
    bus_start();
    write_byte(8'hAA, ack); chk("R5 soft bits kept", 32'(ack), 1);
    bus_stop();
    chk("R5 rx_valid", 32'(rx_valid), 0);
    cfg_soft = 1'b0;

    // R8 stretch on full holding register
    bus_start();
    write_byte(8'hA6, ack);
    write_byte(8'h11, ack); chk("R8 first byte ack", 32'(ack), 1);
    fork
      begin
        logic a2;
        write_byte(8'h22, a2);
        chk("R8 second byte ack after drain", 32'(a2), 1);
      end
      begin
        int n;
        n = 0;
        while (!scl_oe && n < 3000) begin @(negedge clk); n++; end
        repeat (60) @(negedge clk);
        chk("R8 scl held low", 32'(scl_line), 0);
        chk("R8 old byte kept", 32'(rx_data), 32'h11);
        take_pulse();
      end
    join
    chk("R8 new byte", 32'(rx_data), 32'h22);
    take_pulse();
    bus_stop();

    // R9/R10 read two bytes, ACK then NACK
    tx_valid = 1'b1;
    base = n_take;
    bus_start();
    write_byte(8'hA7, ack); chk("R9 read address ack", 32'(ack), 1);
    read_byte(1'b1, d); chk("R9 first read byte", 32'(d), 32'(txpat(base)));
    read_byte(1'b0, d); chk("R10 second byte after ack", 32'(d), 32'(txpat(base + 1)));
    chk("R10 no request after nack", 32'(tx_req), 0);
    chk("R10 sda released", 32'(sda_oe), 0);
    chk("R10 bytes taken", 32'(n_take - base), 2);
    bus_stop();
    tx_valid = 1'b0;

    // R11 stretch while no transmit byte is ready
    base = n_take;
    bus_start();
    write_byte(8'hA7, ack);
    fork
      begin
        logic [7:0] rd;
        read_byte(1'b0, rd);
        chk("R11 byte after stretch", 32'(rd), 32'(txpat(base)));
      end
      begin
        int n;
        n = 0;
        while (!tx_req && n < 3000) begin @(negedge clk); n++; end
        repeat (60) @(negedge clk);
        chk("R11 scl held low", 32'(scl_line), 0);
        tx_valid = 1'b1;
        n = 0;
        while (tx_req && n < 3000) begin @(negedge clk); n++; end
        tx_valid = 1'b0;
      end
    join
    bus_stop();

    // R12 repeated START mid-byte
    bus_start();
    write_byte(8'hA6, ack);
    for (int i = 0; i < 4; i++) bus_bit(1'b1, g);
    bus_start();
    chk("R12 partial byte dropped", 32'(rx_valid), 0);
    write_byte(8'hA6, ack); chk("R12 address after restart", 32'(ack), 1);
    write_byte(8'h29, ack); chk("R12 data after restart", 32'(rx_data), 32'h29);
    take_pulse();
    bus_stop();

    // R12 STOP mid-byte, then a byte with no START
    bus_start();
    write_byte(8'hA6, ack);
    for (int i = 0; i < 3; i++) bus_bit(1'b0, g);
    bus_stop();
    chk("R12 stop drops byte", 32'(rx_valid), 0);
    scl_m = 1'b0; wait_q();
    write_byte(8'hA6, ack); chk("R12 idle after stop", 32'(ack), 0);
    bus_stop();

    finish_run();
  end
endmodule